// File: doc/BRIEF.md
# Streaming Signed Dot-Product Accumulator

This block is one lane of multiply-accumulate arithmetic for a dataflow pipeline. Each clock cycle it can take in one pair of signed operands. It multiplies them, widens the product to the accumulator width and adds it to a running sum. A marker on the final element closes the vector. That marker has the same meaning as the end-of-packet flag on a streaming bus.

When the closing beat is accepted, the block registers the finished sum into its result register and raises a valid strobe for one cycle. The sum includes the product of the closing beat. In the same cycle the accumulator goes back to zero, so the next vector may start on the very next clock without any flush. There is no ready signal, so the producer must never be stalled. The accumulator width parameter must be larger than twice the operand width; the block refuses to elaborate otherwise. Sums that grow past that width wrap in two's complement.

Top module: `dotp_engine`

## Requirements
- R1: The operands `op_a` and `op_b` are signed two's-complement values of DATA_W bits. Their product is computed at full precision, sign-extended to ACC_W bits and added to the running sum.
- R2: A beat is accepted only on a rising clock edge where `beat_valid` is 1, and at most one operand pair is accepted per edge.
- R3: On the edge that accepts a beat with `beat_last` = 1, `sum_out` takes the running sum plus that beat's product. The value is visible right after that edge.
- R4: `sum_valid` is 1 for exactly one cycle after each accepted closing beat, and 0 in every other cycle.
- R5: The accumulator returns to zero on the edge that accepts a closing beat. A beat accepted on the following edge starts a new vector, with no idle cycle needed.
- R6: While `beat_valid` is 0, the running sum keeps its value, and `beat_last`, `op_a` and `op_b` have no effect.
- R7: A vector whose first beat carries `beat_last` = 1 produces exactly that one product.
- R8: While `sum_valid` is 0, `sum_out` keeps the most recent result.
- R9: A sum that leaves the ACC_W-bit signed range wraps in two's complement and is not saturated.
- R10: Asserting `rst_n` low clears the running sum, `sum_out` and `sum_valid` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| beat_valid | input | 1 | The operand pair is to be accepted this cycle |
| beat_last | input | 1 | The operand pair is the final element of its vector |
| op_a | input | DATA_W | First signed operand |
| op_b | input | DATA_W | Second signed operand |
| sum_out | output | ACC_W | Most recent completed dot product, signed |
| sum_valid | output | 1 | One-cycle strobe marking a new `sum_out` |

## Verification
The bench runs a narrow build with 4-bit operands and a 10-bit sum. Every operand pair is sent as a one-beat vector, and every pair is also sent as the first beat of a two-beat vector. A design that treated the operands as unsigned, or zero-extended the product, would get the negative cases wrong. A design that dropped the closing beat's product, or cleared the sum one edge late, would give wrong results on back-to-back vectors. Idle cycles carry the end marker and junk operands, so a design that looked at `beat_last` or the operands without `beat_valid` would emit false results. A long run of maximal products forces a wrap, which a saturating design would get wrong. Reset is applied in the middle of a cycle, both after a result strobe and part-way through a vector; a design with a synchronous reset, or one that kept the partial sum, would fail those checks.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  // Update applied to the running sum on one clock edge.
  typedef enum logic [1:0] {
    SUM_HOLD  = 2'd0,
    SUM_ADD   = 2'd1,
    SUM_CLOSE = 2'd2
  } sum_op_e;

  // Map the beat qualifiers to a sum update; beat_last counts only with valid.
  function automatic sum_op_e decode_beat(input logic valid, input logic last);
    if (!valid)     return SUM_HOLD;
    else if (last)  return SUM_CLOSE;
    else            return SUM_ADD;
  endfunction

endpackage

// File: rtl/dotp_mult.sv
module dotp_mult #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  output logic signed [ACC_W-1:0]  prod_wide
);
  localparam int PROD_W = 2 * DATA_W;

  generate
    if (ACC_W <= PROD_W) begin : g_bad_width
      $error("dotp_mult: ACC_W must exceed 2*DATA_W");
    end
  endgenerate

  // Full-precision signed product, then sign extension to the sum width.
  function automatic logic signed [ACC_W-1:0] widen_product(
    input logic signed [DATA_W-1:0] x,
    input logic signed [DATA_W-1:0] y
  );
    logic signed [PROD_W-1:0] p;
    p = PROD_W'(x) * PROD_W'(y);
    return ACC_W'(p);
  endfunction

  assign prod_wide = widen_product(x_in, y_in);

endmodule

// File: rtl/dotp_accum.sv
module dotp_accum
  import dotp_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  sum_op_e                 op,
  input  logic signed [ACC_W-1:0] addend,
  output logic signed [ACC_W-1:0] acc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      case (op)
        SUM_ADD:   acc_q <= acc_q + addend;
        SUM_CLOSE: acc_q <= '0;
        default:   acc_q <= acc_q;
      endcase
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SUM_HOLD) |=> $stable(acc_q));

  // R5
  close_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SUM_CLOSE) |=> (acc_q == '0));

endmodule

// File: rtl/dotp_result.sv
module dotp_result #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    emit,
  input  logic signed [ACC_W-1:0] total,
  output logic signed [ACC_W-1:0] res_q,
  output logic                    res_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= emit;
      if (emit) res_q <= total;
    end
  end

  // R4
  strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> res_valid);

  // R4
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> !res_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_q));

endmodule

// File: rtl/dotp_engine.sv
module dotp_engine
  import dotp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat_valid,
  input  logic                     beat_last,
  input  logic signed [DATA_W-1:0] op_a,
  input  logic signed [DATA_W-1:0] op_b,
  output logic signed [ACC_W-1:0]  sum_out,
  output logic                     sum_valid
);

  // Named internal events, exposed for the assertions below.
  sum_op_e                 beat_op;
  logic                    close_evt;
  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] closing_total;

  assign beat_op       = decode_beat(beat_valid, beat_last);
  assign close_evt     = (beat_op == SUM_CLOSE);
  assign closing_total = acc_q + prod_ext;

  dotp_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
    .x_in      (op_a),
    .y_in      (op_b),
    .prod_wide (prod_ext)
  );

  dotp_accum #(.ACC_W(ACC_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (beat_op),
    .addend (prod_ext),
    .acc_q  (acc_q)
  );

  dotp_result #(.ACC_W(ACC_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (close_evt),
    .total     (closing_total),
    .res_q     (sum_out),
    .res_valid (sum_valid)
  );

  // R3
  close_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last) |=> (sum_out == $past(acc_q) + $past(prod_ext)));

  // R2
  accept_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (acc_q == $past(acc_q) + $past(prod_ext)));

  // R6
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |=> !sum_valid);

endmodule

// File: tb/tb_dotp_engine.sv
module tb_dotp_engine;
  localparam int DW = 4;
  localparam int AW = 10;

  logic                 clk;
  logic                 rst_n;
  logic                 beat_valid;
  logic                 beat_last;
  logic signed [DW-1:0] op_a;
  logic signed [DW-1:0] op_b;
  logic signed [AW-1:0] sum_out;
  logic                 sum_valid;

  int errors = 0;
  int checks = 0;
  longint run_sum = 0;
  logic signed [AW-1:0] last_res = '0;

  dotp_engine #(.DATA_W(DW), .ACC_W(AW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .op_a       (op_a),
    .op_b       (op_b),
    .sum_out    (sum_out),
    .sum_valid  (sum_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reduce an exact sum to AW bits of two's complement.
  function automatic logic signed [AW-1:0] wrap_to_acc(input longint s);
    longint m;
    m = s % (longint'(1) << AW);
    if (m < 0) m += (longint'(1) << AW);
    if (m >= (longint'(1) << (AW - 1))) m -= (longint'(1) << AW);
    return AW'(m);
  endfunction

  task automatic check_out(input string req, input logic exp_v,
                           input logic signed [AW-1:0] exp_d);
    checks++;
    if (sum_valid !== exp_v || sum_out !== exp_d) begin
      errors++;
      $display("FAIL %s: sum_valid=%0b sum_out=%0d expected sum_valid=%0b sum_out=%0d",
               req, sum_valid, sum_out, exp_v, exp_d);
    end
  endtask

  // Called at a falling edge: drive one beat, pass one rising edge, check.
  task automatic step(input logic v, input logic l, input int av, input int bv,
                      input string req);
    logic ev;
    beat_valid = v;
    beat_last  = l;
    op_a       = DW'(av);
    op_b       = DW'(bv);
    ev         = v && l;
    if (v) run_sum += longint'(av) * longint'(bv);
    if (ev) begin
      last_res = wrap_to_acc(run_sum);
      run_sum  = 0;
    end
    @(negedge clk);
    check_out(req, ev, last_res);
  endtask

  task automatic mid_cycle_reset(input string req);
    #5 rst_n = 1'b0;
    #2;
    run_sum  = 0;
    last_res = '0;
    check_out(req, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; beat_valid = 1'b0; beat_last = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check_out("R10 reset state", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7, R1: every signed pair as a one-beat vector
    for (int x = -8; x < 8; x++)
      for (int y = -8; y < 8; y++)
        step(1'b1, 1'b1, x, y, "R7 R1 single-beat vector");

    // R2, R1, R5: every pair as the first beat of a two-beat vector, back to back
    for (int x = -8; x < 8; x++)
      for (int y = -8; y < 8; y++) begin
        step(1'b1, 1'b0, x, y, "R2 R1 first beat");
        step(1'b1, 1'b1, -x - 1, y, "R5 R3 closing beat");
      end

    // R6, R8: idle cycles with marker and junk operands in the middle of vectors
    for (int len = 1; len <= 6; len++) begin
      for (int k = 0; k < len; k++) begin
        step(1'b0, 1'b1, 7, 7, "R6 idle marker ignored");
        step(1'b1, (k == len - 1), k - 4, 3 - len, "R3 R4 mixed vector");
        step(1'b0, 1'b0, -8, 5, "R8 result held");
      end
    end

    // R9: ten products of 64 reach 640, which wraps to -384 in 10 bits
    for (int k = 0; k < 10; k++)
      step(1'b1, (k == 9), -8, -8, "R9 wrap");
    checks++;
    if (last_res !== -10'sd384) begin
      errors++;
      $display("FAIL R9 model: actual=%0d expected=-384", last_res);
    end

    // R10: asynchronous reset while the result strobe is high
    step(1'b1, 1'b0, 5, 5, "R2 pre-reset");
    step(1'b1, 1'b1, 1, 2, "R3 pre-reset close");
    mid_cycle_reset("R10 reset clears strobe");
    // R10: asynchronous reset part-way through a vector
    step(1'b1, 1'b0, 3, 3, "R2 partial");
    step(1'b1, 1'b0, 2, 5, "R2 partial");
    mid_cycle_reset("R10 reset mid-vector");
    step(1'b1, 1'b1, -2, 3, "R10 sum cleared by reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule